// File: doc/BRIEF.md
# Framebuffer Write Scheduler

This block sits between a host that produces pixel updates and a single-port video RAM that the display engine also reads. The host pushes write requests, each a framebuffer address and an intensity value. Address and intensity are stored side by side in one queue entry, so the two can never fall out of step. The scheduler drains the queue into the RAM, but only in cycles where a write cannot disturb a pixel fetch.

Two scheduling modes are offered. In blanking mode, the clock is the pixel clock. Writes go out only when the display is inactive and a horizontal or vertical blank is flagged by the timing generator. During active display the RAM address bus carries the display address. In interleaved mode, the clock runs at twice the pixel rate. Cycles alternate between a display-read slot and a write slot, so writes proceed even during active display.

A 16-bit address covers a 64K-byte, 256 x 256 framebuffer. The host watches a registered full flag. A push made while full is thrown away, and it raises a sticky overflow flag that stays set until reset.

Top module: `fb_write_sched`

## Requirements
- R1: When `pushValid` is high and `queueFull` is low, the address and data are accepted. Accepted entries reach the RAM in the order they were pushed, with `ramAddr` and `ramWData` taken from the same entry in the cycle that `ramWe` is high.
- R2: `queueFull` is a registered flag. It is high exactly when DEPTH entries (default 16) are held, counted after the previous clock edge.
- R3: A push made while `queueFull` is high is discarded. `overflow` goes high on the next edge and stays high until `rstN` is asserted.
- R4: When `modeInterleave` is 0 (blanking mode), `ramWe` is high only in cycles where `dispActive` is 0 and at least one of `hBlank` or `vBlank` is 1.
- R5: In blanking mode with `dispActive` high, `ramWe` is 0 and `ramAddr` equals `dispAddr`.
- R6: When `modeInterleave` is 1, the cycles alternate between slots. The first cycle after reset release is a read slot, the next is a write slot, and so on. `ramWe` can be high only in write slots. In a read slot, `ramAddr` equals `dispAddr`.
- R7: In every permitted slot where the queue holds an entry, `ramWe` is high and exactly one entry is removed. No more than one entry is removed per cycle.
- R8: After reset, the queue is empty, `queueFull` and `overflow` are 0, and `ramWe` is 0. `ramWData` reads 0 whenever `ramWe` is 0.
- R9: The empty flag is registered. An entry pushed into an empty queue is written no earlier than the cycle after it is pushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock in blanking mode; double-rate RAM clock in interleaved mode |
| rstN | input | 1 | Active-low synchronous reset |
| modeInterleave | input | 1 | 0 = blanking-interval writes, 1 = alternating read/write slots |
| pushValid | input | 1 | Host push request |
| pushAddr | input | 16 | Framebuffer address of the pixel |
| pushData | input | 8 | Pixel intensity |
| queueFull | output | 1 | Queue holds DEPTH entries; host must not push |
| overflow | output | 1 | Sticky flag: a push was dropped while full |
| dispActive | input | 1 | Timing generator: visible pixel region |
| hBlank | input | 1 | Timing generator: horizontal blank (porches and sync) |
| vBlank | input | 1 | Timing generator: vertical blank |
| dispAddr | input | 16 | Address from the display counters |
| ramAddr | output | 16 | RAM address bus |
| ramWData | output | 8 | RAM write data |
| ramWe | output | 1 | RAM write strobe |

## Verification
The hardest state to reach from the ports is a full queue that is popped and pushed in the same cycle. A registered full flag must still refuse the push even though room is opening. To get there, the stimulus keeps display active in blanking mode while pushing more than DEPTH entries. It then opens a blanking window while the host keeps pushing. A long random phase mixes modes, blanking patterns and push rates. In that phase, interleaved slots meet both an empty queue and freshly pushed entries on either slot parity.

// File: rtl/fbws_pkg.sv
package fbws_pkg;

  // Strobes from control to datapath for one clock cycle.
  typedef struct packed {
    logic doPush;    // store the host word at the tail
    logic doPop;     // retire the head entry
    logic selWrite;  // steer the head entry onto the RAM bus
  } fbws_strobe_t;

endpackage

// File: rtl/fbws_datapath.sv
module fbws_datapath
  import fbws_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbws_strobe_t      strobe,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [DATA_W-1:0] pushData,
  input  logic [ADDR_W-1:0] dispAddr,
  output logic              qEmpty,
  output logic              qFull,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } entry_t;

  entry_t            slots [DEPTH];
  entry_t            headEntry;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fill, fillNext;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  // Address and intensity share one entry, so they move in lockstep.
  always_ff @(posedge clk) begin
    if (strobe.doPush) slots[wrPtr] <= {pushAddr, pushData};
  end

  always_comb begin
    fillNext = fill;
    if (strobe.doPush && !strobe.doPop) fillNext = fill + 1'b1;
    if (!strobe.doPush && strobe.doPop) fillNext = fill - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      fill   <= '0;
      qEmpty <= 1'b1;
      qFull  <= 1'b0;
    end else begin
      if (strobe.doPush) wrPtr <= bumpPtr(wrPtr);
      if (strobe.doPop)  rdPtr <= bumpPtr(rdPtr);
      fill   <= fillNext;
      qEmpty <= (fillNext == '0);
      qFull  <= (fillNext == FULL_CNT);
    end
  end

  assign headEntry = slots[rdPtr];

  always_comb begin
    if (strobe.selWrite) begin
      ramAddr  = headEntry.addr;
      ramWData = headEntry.data;
    end else begin
      ramAddr  = dispAddr;
      ramWData = '0;
    end
  end

  a_r7_pop_needs_entry: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doPop |-> !qEmpty);
  a_r2_push_needs_room: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doPush |-> !qFull);
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(qEmpty && qFull));
  a_r9_push_fills: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doPush && !strobe.doPop) |=> !qEmpty);

endmodule

// File: rtl/fbws_ctrl.sv
module fbws_ctrl
  import fbws_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeInterleave,
  input  logic         pushValid,
  input  logic         dispActive,
  input  logic         hBlank,
  input  logic         vBlank,
  input  logic         qEmpty,
  input  logic         qFull,
  output fbws_strobe_t strobe,
  output logic         ramWe,
  output logic         overflow
);

  logic writePhase;
  logic slotOpen;

  // Slot parity: read slot first after reset, then write, alternating.
  always_ff @(posedge clk) begin
    if (!rstN) writePhase <= 1'b0;
    else       writePhase <= ~writePhase;
  end

  always_comb begin
    if (modeInterleave) slotOpen = writePhase;
    else                slotOpen = !dispActive && (hBlank || vBlank);
  end

  always_comb begin
    strobe.doPush   = pushValid && !qFull;
    strobe.doPop    = slotOpen && !qEmpty;
    strobe.selWrite = strobe.doPop;
  end

  assign ramWe = strobe.doPop;

  always_ff @(posedge clk) begin
    if (!rstN)                  overflow <= 1'b0;
    else if (pushValid && qFull) overflow <= 1'b1;
  end

  a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  a_r3_overflow_on_drop: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && qFull) |=> overflow);
  a_r4_blank_window: assert property (@(posedge clk) disable iff (!rstN)
    (!modeInterleave && ramWe) |-> (!dispActive && (hBlank || vBlank)));
  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    (modeInterleave && ramWe) |=> !(modeInterleave && ramWe));

endmodule

// File: rtl/fb_write_sched.sv
module fb_write_sched
  import fbws_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeInterleave,
  input  logic              pushValid,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [DATA_W-1:0] pushData,
  output logic              queueFull,
  output logic              overflow,
  input  logic              dispActive,
  input  logic              hBlank,
  input  logic              vBlank,
  input  logic [ADDR_W-1:0] dispAddr,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWData,
  output logic              ramWe
);

  fbws_strobe_t strobe;
  logic         qEmpty;
  logic         qFull;

  fbws_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .modeInterleave (modeInterleave),
    .pushValid      (pushValid),
    .dispActive     (dispActive),
    .hBlank         (hBlank),
    .vBlank         (vBlank),
    .qEmpty         (qEmpty),
    .qFull          (qFull),
    .strobe         (strobe),
    .ramWe          (ramWe),
    .overflow       (overflow)
  );

  fbws_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pushAddr (pushAddr),
    .pushData (pushData),
    .dispAddr (dispAddr),
    .qEmpty   (qEmpty),
    .qFull    (qFull),
    .ramAddr  (ramAddr),
    .ramWData (ramWData)
  );

  assign queueFull = qFull;

  a_r5_display_owns_bus: assert property (@(posedge clk) disable iff (!rstN)
    (!modeInterleave && dispActive) |-> (!ramWe && ramAddr == dispAddr));
  a_r8_idle_data_zero: assert property (@(posedge clk) disable iff (!rstN)
    !ramWe |-> (ramWData == '0));

endmodule

// File: tb/fb_write_sched_bench.sv
module fb_write_sched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeInterleave = 1'b0;
  logic        pushValid = 1'b0;
  logic [15:0] pushAddr = '0;
  logic [7:0]  pushData = '0;
  logic        queueFull, overflow;
  logic        dispActive = 1'b0;
  logic        hBlank = 1'b0;
  logic        vBlank = 1'b0;
  logic [15:0] dispAddr = '0;
  logic [15:0] ramAddr;
  logic [7:0]  ramWData;
  logic        ramWe;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  // Reference model state
  logic [23:0] mq[$];
  bit          mPhase;
  bit          mOvf;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_write_sched #(.ADDR_W(16), .DATA_W(8), .DEPTH(DEPTH)) u_fb_write_sched (
    .clk(clk), .rstN(rstN), .modeInterleave(modeInterleave),
    .pushValid(pushValid), .pushAddr(pushAddr), .pushData(pushData),
    .queueFull(queueFull), .overflow(overflow),
    .dispActive(dispActive), .hBlank(hBlank), .vBlank(vBlank),
    .dispAddr(dispAddr), .ramAddr(ramAddr), .ramWData(ramWData), .ramWe(ramWe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic modelReset();
    mq.delete();
    mPhase = 0;
    mOvf   = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    pushValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    #1;
    // R8: reset state
    check("R8 ramWe", ramWe, 0);
    check("R8 queueFull", queueFull, 0);
    check("R8 overflow", overflow, 0);
    check("R8 ramWData", ramWData, 0);
  endtask

  // One cycle: drive at negedge (already there), compare, then advance model.
  task automatic cycle(input bit mode, input bit push, input logic [15:0] pa,
                       input logic [7:0] pd, input bit da, input bit hb, input bit vb,
                       input logic [15:0] ca);
    bit slot, we, full, empty;
    logic [15:0] eAddr;
    logic [7:0]  eData;
    modeInterleave = mode; pushValid = push; pushAddr = pa; pushData = pd;
    dispActive = da; hBlank = hb; vBlank = vb; dispAddr = ca;
    #1;
    full  = (mq.size() == DEPTH);
    empty = (mq.size() == 0);
    slot  = mode ? mPhase : (!da && (hb || vb));
    we    = slot && !empty;
    eAddr = we ? mq[0][23:8] : ca;
    eData = we ? mq[0][7:0] : 8'h00;
    if (empty)          check("R9 ramWe", ramWe, we);
    else if (mode)      check("R6 ramWe", ramWe, we);
    else if (da)        check("R5 ramWe", ramWe, we);
    else                check("R4 ramWe", ramWe, we);
    if (!we && (mode || da)) check(mode ? "R6 ramAddr" : "R5 ramAddr", ramAddr, eAddr);
    else                     check("R1 ramAddr", ramAddr, eAddr);
    check(we ? "R1 ramWData" : "R8 ramWData", ramWData, eData);
    check("R2 queueFull", queueFull, full);
    check("R3 overflow", overflow, mOvf);
    if (we) void'(mq.pop_front());
    if (push && !full) mq.push_back({pa, pd});
    if (push && full) mOvf = 1;
    mPhase = ~mPhase;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    doReset();
    // Idle in blanking mode.
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 1, 0, 0, 16'(i));
    // R2/R3/R5: fill during active display, push past full.
    for (int i = 0; i < DEPTH + 4; i++)
      cycle(0, 1, 16'h1000 + 16'(i), 8'(i * 3), 1, 0, 0, 16'h0200 + 16'(i));
    // Full queue popped while the host keeps pushing (horizontal blank).
    for (int i = 0; i < 6; i++)
      cycle(0, 1, 16'h2000 + 16'(i), 8'(i + 100), 0, 1, 0, 16'h0300);
    // Drain in vertical blank; display inactive but no blank flag first.
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, 0, 0, 0, 16'h0400);
    for (int i = 0; i < DEPTH + 4; i++) cycle(0, 0, 0, 0, 0, 0, 1, 16'h0500);
    // R3: overflow cleared only by reset.
    doReset();
    // R6/R9: interleaved mode during active display, push on each parity.
    for (int i = 0; i < 24; i++)
      cycle(1, (i % 3) == 0, 16'hA000 + 16'(i), 8'(200 - i), 1, 0, 0, 16'h0600 + 16'(i));
    for (int i = 0; i < DEPTH * 3; i++)
      cycle(1, 1, 16'hB000 + 16'(i), 8'(i), 1, 0, 0, 16'h0700);
    // Random mix.
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      cycle(r[0] & r[1], r[2] | r[3], 16'($urandom), 8'($urandom),
            r[4] | r[5], r[6], r[7] & r[8], 16'($urandom));
      if (i == 2000) doReset();
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule